// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits behind a bank of timer channels. It turns each channel's one-cycle fire pulse into an interrupt. The interrupt can take three forms: a held level with a status bit, a one-cycle pulse on an interrupt line, or a 32-bit message write on the system bus. Each channel has a configuration word that selects the form. The word holds a channel enable, a level/edge type bit, a 5-bit line selector and a message enable. A global enable gates every channel.

The block also owns two lines that outside sources normally drive. Line 0 carries an external interval-timer interrupt and line 8 carries an external clock-chip interrupt. A legacy replacement mode takes both lines over: channel 0 then drives line 0 and channel 1 drives line 8. In the same mode the interval-timer enable output goes low. Lines numbered 16 and above are wired to inverting sinks, so they idle high and assert low.

Top module: `irq_route_unit`

## Requirements
- R1: Outside legacy mode, a channel drives the line whose index sits in bits 13:9 of its configuration word. Bit 2 of the word is the channel enable, bit 1 selects level (1) or edge (0), and bit 14 is the message enable.
- R2: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their line selectors hold. All other channels keep their selectors.
- R3: A fire on an enabled level-type channel sets that channel's status bit and asserts its line at the next clock edge. Both stay set until they are cleared.
- R4: A fire on an enabled edge-type channel clears its status bit and asserts its line for exactly one cycle.
- R5: Lines 0 to 15 are active high. Lines 16 to 23 are active low, so they read 1 while idle. Out of reset every line is idle.
- R6: A status write clears each status bit whose write-data bit is 1, and deasserts the matching line. Write-data bits of 0 have no effect, and neither does a 1 aimed at a bit that is already clear.
- R7: If a channel's enable or the global enable is 0, that channel's status bit is cleared and its line is deasserted at the next edge.
- R8: A fire on an enabled channel whose message enable is 1 raises a write request two edges later. The address is bits 63:32 of the channel's route register and the data is bits 31:0. No line and no status bit changes.
- R9: A pending write keeps its valid, address and data unchanged until ready is seen high. When several channels have writes pending, the lowest-numbered channel goes first.
- R10: When a channel's message enable changes from 0 to 1, its status bit is cleared and its line is deasserted at the next edge.
- R11: Entering legacy mode drives the interval-timer enable low and removes the external inputs from lines 0 and 8. Leaving legacy mode drives the enable high, and line 8 then shows the last clock-chip level, including any level sampled while in legacy mode.
- R12: Outside legacy mode, line 0 follows the interval-timer input and line 8 follows the clock-chip input, each one edge later.
- R13: If a level-type fire and a status write that clears the same bit arrive in the same cycle, the fire wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire_i | input | NUM_CH | Per-channel fire pulse |
| ch_cfg_i | input | NUM_CH*15 | Per-channel configuration words, channel 0 in the low bits |
| route_reg_i | input | NUM_CH*64 | Per-channel message route: address in the upper half, data in the lower half |
| glob_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy replacement mode |
| sts_wr_i | input | 1 | Status write strobe |
| sts_wdata_i | input | NUM_CH | Status write data, write 1 to clear |
| pit_in_i | input | 1 | External interval-timer interrupt input |
| rtc_in_i | input | 1 | External clock-chip interrupt input |
| msg_ready_i | input | 1 | Message write accepted |
| irq_o | output | 24 | Interrupt line vector, upper lines inverted |
| pit_en_o | output | 1 | Interval-timer enable |
| sts_o | output | NUM_CH | Per-channel status bits |
| msg_valid_o | output | 1 | Message write request |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
A level-type fire and a status write that clears the same channel can fall in the same cycle. The bench provokes this twice: once with the bit already set and once with it clear. Both times it expects the bit and the line to be set one edge later. A second overlap arises when two message channels fire together. Their requests then queue, and the bench judges the order from the address that appears on each accepted write while ready is held low.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
    localparam int CFG_W     = 15;
    localparam int LVL_BIT   = 1;
    localparam int EN_BIT    = 2;
    localparam int ROUTE_LSB = 9;
    localparam int ROUTE_W   = 5;
    localparam int MSG_BIT   = 14;
    localparam int RREG_W    = 64;
    localparam int HALF_W    = RREG_W / 2;

    typedef struct packed {
        logic               en;
        logic               lvl;
        logic               msg;
        logic [ROUTE_W-1:0] route;
    } chan_cfg_t;

    function automatic chan_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        chan_cfg_t c;
        c.en    = w[EN_BIT];
        c.lvl   = w[LVL_BIT];
        c.msg   = w[MSG_BIT];
        c.route = w[ROUTE_LSB +: ROUTE_W];
        return c;
    endfunction
endpackage

// File: rtl/irq_chan.sv
module irq_chan
    import irq_route_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fire_i,
    input  logic      glob_en_i,
    input  logic      clr_i,
    input  chan_cfg_t cfg_i,
    output logic      sts_o,
    output logic      pulse_o,
    output logic      msg_req_o
);
    typedef struct packed {
        logic sts;
        logic pulse;
        logic msg_prev;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     live;

    always_comb begin
        st_d          = st_q;
        st_d.pulse    = 1'b0;
        st_d.msg_prev = cfg_i.msg;
        msg_req_o     = 1'b0;
        live          = cfg_i.en && glob_en_i;
        if (clr_i)
            st_d.sts = 1'b0;
        if (cfg_i.msg && !st_q.msg_prev)
            st_d.sts = 1'b0;
        if (fire_i && live) begin
            if (cfg_i.msg) begin
                msg_req_o = 1'b1;
            end else if (cfg_i.lvl) begin
                st_d.sts = 1'b1;
            end else begin
                st_d.sts   = 1'b0;
                st_d.pulse = 1'b1;
            end
        end
        if (!live) begin
            st_d.sts   = 1'b0;
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o   = st_q.sts;
    assign pulse_o = st_q.pulse;

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_i.en || !glob_en_i) |=> (!sts_o && !pulse_o));
    assert_msg_rise_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i.msg |=> !sts_o);
    assert_wr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fire_i) |=> !sts_o);
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && !fire_i) |=> !pulse_o);
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
    import irq_route_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        req_i,
    input  logic [NUM_CH*RREG_W-1:0] route_reg_i,
    input  logic                     ready_i,
    output logic                     valid_o,
    output logic [HALF_W-1:0]        addr_o,
    output logic [HALF_W-1:0]        data_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] pend;
        logic              valid;
        logic [HALF_W-1:0] addr;
        logic [HALF_W-1:0] data;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    found;

    always_comb begin
        st_d  = st_q;
        found = 1'b0;
        if (st_q.valid && ready_i)
            st_d.valid = 1'b0;
        if (!st_q.valid) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (!found && st_q.pend[c]) begin
                    found        = 1'b1;
                    st_d.valid   = 1'b1;
                    st_d.addr    = route_reg_i[c*RREG_W + HALF_W +: HALF_W];
                    st_d.data    = route_reg_i[c*RREG_W +: HALF_W];
                    st_d.pend[c] = 1'b0;
                end
            end
        end
        st_d.pend = st_d.pend | req_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign addr_o  = st_q.addr;
    assign data_o  = st_q.data;

    assert_msg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));
endmodule

// File: rtl/irq_line_mux.sv
module irq_line_mux
    import irq_route_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24,
    parameter int INV_FROM  = 16,
    parameter int PIT_LINE  = 0,
    parameter int RTC_LINE  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH-1:0]         sts_i,
    input  logic [NUM_CH-1:0]         pulse_i,
    input  logic [NUM_CH*ROUTE_W-1:0] route_i,
    input  logic                      legacy_i,
    input  logic                      pit_in_i,
    input  logic                      rtc_in_i,
    output logic [NUM_LINES-1:0]      lines_o,
    output logic                      pit_en_o
);
    typedef struct packed {
        logic legacy;
        logic pit;
        logic rtc;
    } mux_st_t;

    mux_st_t              st_d, st_q;
    logic [NUM_LINES-1:0] act;
    int                   eff;

    always_comb begin
        st_d.legacy = legacy_i;
        st_d.pit    = pit_in_i;
        st_d.rtc    = rtc_in_i;
        act         = '0;
        eff         = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            eff = int'(route_i[c*ROUTE_W +: ROUTE_W]);
            if (st_q.legacy && c == 0) eff = PIT_LINE;
            if (st_q.legacy && c == 1) eff = RTC_LINE;
            for (int l = 0; l < NUM_LINES; l++)
                if ((sts_i[c] || pulse_i[c]) && eff == l) act[l] = 1'b1;
        end
        if (!st_q.legacy) begin
            act[PIT_LINE] = act[PIT_LINE] | st_q.pit;
            act[RTC_LINE] = act[RTC_LINE] | st_q.rtc;
        end
        for (int l = 0; l < NUM_LINES; l++)
            lines_o[l] = (l >= INV_FROM) ? !act[l] : act[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pit_en_o = !st_q.legacy;

    assert_legacy_takeover_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_i && !(sts_i[0] || pulse_i[0]) && !(sts_i[1] || pulse_i[1]))
            |=> (!pit_en_o && (sts_i[0] || pulse_i[0] || !lines_o[PIT_LINE])));
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_LINES = 24,
    parameter int INV_FROM  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        fire_i,
    input  logic [NUM_CH*CFG_W-1:0]  ch_cfg_i,
    input  logic [NUM_CH*RREG_W-1:0] route_reg_i,
    input  logic                     glob_en_i,
    input  logic                     legacy_i,
    input  logic                     sts_wr_i,
    input  logic [NUM_CH-1:0]        sts_wdata_i,
    input  logic                     pit_in_i,
    input  logic                     rtc_in_i,
    input  logic                     msg_ready_i,
    output logic [NUM_LINES-1:0]     irq_o,
    output logic                     pit_en_o,
    output logic [NUM_CH-1:0]        sts_o,
    output logic                     msg_valid_o,
    output logic [HALF_W-1:0]        msg_addr_o,
    output logic [HALF_W-1:0]        msg_data_o
);
    logic [NUM_CH-1:0]         pulse;
    logic [NUM_CH-1:0]         msg_req;
    logic [NUM_CH*ROUTE_W-1:0] route_flat;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_cfg_t cfg;
        assign cfg = decode_cfg(ch_cfg_i[c*CFG_W +: CFG_W]);
        assign route_flat[c*ROUTE_W +: ROUTE_W] = cfg.route;

        irq_chan chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire_i    (fire_i[c]),
            .glob_en_i (glob_en_i),
            .clr_i     (sts_wr_i && sts_wdata_i[c]),
            .cfg_i     (cfg),
            .sts_o     (sts_o[c]),
            .pulse_o   (pulse[c]),
            .msg_req_o (msg_req[c])
        );
    end

    irq_msg_arb #(.NUM_CH(NUM_CH)) arb_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (msg_req),
        .route_reg_i (route_reg_i),
        .ready_i     (msg_ready_i),
        .valid_o     (msg_valid_o),
        .addr_o      (msg_addr_o),
        .data_o      (msg_data_o)
    );

    irq_line_mux #(
        .NUM_CH    (NUM_CH),
        .NUM_LINES (NUM_LINES),
        .INV_FROM  (INV_FROM)
    ) mux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sts_i    (sts_o),
        .pulse_i  (pulse),
        .route_i  (route_flat),
        .legacy_i (legacy_i),
        .pit_in_i (pit_in_i),
        .rtc_in_i (rtc_in_i),
        .lines_o  (irq_o),
        .pit_en_o (pit_en_o)
    );

    assert_msg_no_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|msg_req) && !sts_wr_i) |=> ((sts_o & $past(msg_req)) == '0));
endmodule

// File: tb/irq_route_unit_tb.sv
module irq_route_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int NL  = 24;
    localparam logic [NL-1:0] INV = 24'hFF0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  fire = '0;
    logic [NCH*15-1:0] cfg = '0;
    logic [NCH*64-1:0] rreg = '0;
    logic            glob_en = 1'b0, legacy = 1'b0, sts_wr = 1'b0;
    logic [NCH-1:0]  sts_wdata = '0;
    logic            pit_in = 1'b0, rtc_in = 1'b0, ready = 1'b0;
    logic [NL-1:0]   irq;
    logic            pit_en, mvalid;
    logic [NCH-1:0]  sts;
    logic [31:0]     maddr, mdata;
    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_route_unit dut_i (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .ch_cfg_i(cfg), .route_reg_i(rreg),
        .glob_en_i(glob_en), .legacy_i(legacy), .sts_wr_i(sts_wr), .sts_wdata_i(sts_wdata),
        .pit_in_i(pit_in), .rtc_in_i(rtc_in), .msg_ready_i(ready), .irq_o(irq),
        .pit_en_o(pit_en), .sts_o(sts), .msg_valid_o(mvalid), .msg_addr_o(maddr),
        .msg_data_o(mdata)
    );

    function automatic logic [NL-1:0] lines(input logic [NL-1:0] act);
        return act ^ INV;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int c, input bit en, input bit lvl, input bit msg, input int route);
        cfg[c*15 +: 15] = 15'((int'(msg) << 14) | (route << 9) | (int'(en) << 2) | (int'(lvl) << 1));
    endtask

    task automatic fire_ch(input logic [NCH-1:0] m);
        @(negedge clk) fire = m;
        @(negedge clk) fire = '0;
    endtask

    task automatic wr_sts(input logic [NCH-1:0] m);
        @(negedge clk) begin sts_wr = 1'b1; sts_wdata = m; end
        @(negedge clk) begin sts_wr = 1'b0; sts_wdata = '0; end
    endtask

    task automatic clean();
        @(negedge clk) begin cfg = '0; legacy = 1'b0; pit_in = 1'b0; rtc_in = 1'b0; glob_en = 1'b1; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R5 reset lines", 64'(irq), 64'(lines('0)));
        chk("R11 reset pit_en", 64'(pit_en), 64'd1);
        chk("R8 reset valid", 64'(mvalid), 64'd0);
        chk("R3 reset sts", 64'(sts), 64'd0);
    endtask

    task automatic t_level_route();
        clean();
        set_cfg(2, 1, 1, 0, 5);
        set_cfg(3, 1, 1, 0, 20);
        fire_ch(4'b0100);
        chk("R1 R3 level line5", 64'(irq), 64'(lines(24'h000020)));
        chk("R3 status set", 64'(sts), 64'h4);
        fire_ch(4'b1000);
        chk("R5 inverted line20", 64'(irq), 64'(lines(24'h100020)));
        @(negedge clk);
        chk("R3 level held", 64'(irq), 64'(lines(24'h100020)));
    endtask

    task automatic t_status_clear();
        wr_sts(4'b0000);
        chk("R6 zero write no effect", 64'(sts), 64'hC);
        wr_sts(4'b0001);
        chk("R6 clear of clear bit", 64'(irq), 64'(lines(24'h100020)));
        wr_sts(4'b0100);
        chk("R6 clear ch2", 64'(sts), 64'h8);
        chk("R6 line5 drop", 64'(irq), 64'(lines(24'h100000)));
        wr_sts(4'b1000);
        chk("R6 clear ch3 line20 idle", 64'(irq), 64'(lines('0)));
    endtask

    task automatic t_edge();
        clean();
        set_cfg(1, 1, 0, 0, 17);
        fire_ch(4'b0010);
        chk("R4 pulse active", 64'(irq), 64'(lines(24'h020000)));
        chk("R4 no status", 64'(sts), 64'h0);
        @(negedge clk);
        chk("R4 pulse ended", 64'(irq), 64'(lines('0)));
    endtask

    task automatic t_disable();
        clean();
        set_cfg(0, 1, 1, 0, 3);
        fire_ch(4'b0001);
        chk("R3 line3 set", 64'(irq), 64'(lines(24'h000008)));
        @(negedge clk) set_cfg(0, 0, 1, 0, 3);
        @(negedge clk);
        chk("R7 chan disable sts", 64'(sts), 64'h0);
        chk("R7 chan disable line", 64'(irq), 64'(lines('0)));
        @(negedge clk) set_cfg(0, 1, 1, 0, 3);
        fire_ch(4'b0001);
        @(negedge clk) glob_en = 1'b0;
        @(negedge clk);
        chk("R7 global disable", 64'(irq), 64'(lines('0)));
        fire_ch(4'b0001);
        chk("R7 fire while off", 64'(sts), 64'h0);
    endtask

    task automatic t_legacy();
        clean();
        @(negedge clk) begin pit_in = 1'b1; rtc_in = 1'b1; end
        @(negedge clk);
        chk("R12 pass-through", 64'(irq), 64'(lines(24'h000101)));
        @(negedge clk) legacy = 1'b1;
        @(negedge clk);
        chk("R11 enter pit_en", 64'(pit_en), 64'd0);
        chk("R11 enter lines low", 64'(irq), 64'(lines('0)));
        set_cfg(0, 1, 1, 0, 10);
        set_cfg(1, 1, 1, 0, 11);
        fire_ch(4'b0001);
        chk("R2 ch0 to line0", 64'(irq), 64'(lines(24'h000001)));
        fire_ch(4'b0010);
        chk("R2 ch1 to line8", 64'(irq), 64'(lines(24'h000101)));
        wr_sts(4'b0011);
        @(negedge clk) begin cfg = '0; pit_in = 1'b0; rtc_in = 1'b0; end
        @(negedge clk) rtc_in = 1'b1;
        @(negedge clk) legacy = 1'b0;
        @(negedge clk);
        chk("R11 leave pit_en", 64'(pit_en), 64'd1);
        chk("R11 leave line8 rtc", 64'(irq), 64'(lines(24'h000100)));
    endtask

    task automatic t_msg();
        clean();
        rreg[2*64 +: 64] = 64'hA000_0020_D000_0002;
        rreg[3*64 +: 64] = 64'hA000_0030_D000_0003;
        set_cfg(2, 1, 1, 1, 4);
        set_cfg(3, 1, 0, 1, 6);
        @(negedge clk);
        fire_ch(4'b1100);
        chk("R8 no line", 64'(irq), 64'(lines('0)));
        chk("R8 no status", 64'(sts), 64'h0);
        @(negedge clk);
        chk("R8 valid", 64'(mvalid), 64'd1);
        chk("R9 first is ch2 addr", 64'(maddr), 64'hA000_0020);
        chk("R8 data", 64'(mdata), 64'hD000_0002);
        @(negedge clk);
        chk("R9 held", 64'({mvalid, maddr}), {31'd0, 1'b1, 32'hA000_0020});
        ready = 1'b1;
        @(negedge clk) ready = 1'b0;
        chk("R9 accepted", 64'(mvalid), 64'd0);
        @(negedge clk);
        chk("R9 second ch3", 64'({mvalid, maddr}), {31'd0, 1'b1, 32'hA000_0030});
        chk("R8 data ch3", 64'(mdata), 64'hD000_0003);
        ready = 1'b1;
        @(negedge clk) ready = 1'b0;
        chk("R9 drained", 64'(mvalid), 64'd0);
    endtask

    task automatic t_msg_rise();
        clean();
        set_cfg(0, 1, 1, 0, 6);
        fire_ch(4'b0001);
        chk("R3 line6", 64'(irq), 64'(lines(24'h000040)));
        @(negedge clk) set_cfg(0, 1, 1, 1, 6);
        @(negedge clk);
        chk("R10 msg rise clears", 64'({sts, irq}), 64'({4'h0, lines('0)}));
    endtask

    task automatic t_collide();
        clean();
        set_cfg(2, 1, 1, 0, 7);
        @(negedge clk) begin fire = 4'b0100; sts_wr = 1'b1; sts_wdata = 4'b0100; end
        @(negedge clk) begin fire = '0; sts_wr = 1'b0; sts_wdata = '0; end
        chk("R13 fire wins from clear", 64'(irq), 64'(lines(24'h000080)));
        @(negedge clk) begin fire = 4'b0100; sts_wr = 1'b1; sts_wdata = 4'b0100; end
        @(negedge clk) begin fire = '0; sts_wr = 1'b0; sts_wdata = '0; end
        chk("R13 fire wins when set", 64'(sts), 64'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level_route();
        t_status_clear();
        t_edge();
        t_disable();
        t_legacy();
        t_msg();
        t_msg_rise();
        t_collide();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule